// File: doc/BRIEF.md
# Receive Buffer Sequence Tagger

This block keeps the two sequence numbers that a receive engine stamps onto every packet it stores. One number names the receive buffer area currently being filled. The other counts packets inside that area. Both are 8 bits wide and wrap modulo 256. Software uses them to work out when every packet of a buffer area has been consumed.

The receive engine reports three kinds of event. A packet has been stored. The engine has moved to a fresh buffer area. The current move was caused by a resource-read command. A write port lets software load both counters at once, and writing zero clears them.

The block exposes two values. `tag_o` is the word to place in the descriptor of the packet stored in the current cycle. `seq_word_o` is the registered counter state.

Top module: `rx_seq_tagger`

## Requirements
- R1: After reset is asserted (`rst_n` low), `seq_word_o` and `tag_o` are 0.
- R2: Bits 15:8 of `seq_word_o` and `tag_o` hold the buffer-area number and bits 7:0 hold the packet number.
- R3: A cycle with `pkt_stored_i` high, and `area_advance_i` and `wr_en_i` low, adds 1 to the packet number and leaves the area number unchanged.
- R4: A cycle with `area_advance_i` high, and `rsrc_read_i` and `wr_en_i` low, adds 1 to the area number and clears the packet number.
- R5: When `rsrc_read_i` is high, `area_advance_i` has no effect on either counter. `rsrc_read_i` on its own changes nothing.
- R6: Both counters wrap from 255 to 0. A wrap of the packet number leaves the area number unchanged.
- R7: When `wr_en_i` is high, the next cycle shows `seq_word_o` equal to `wr_data_i`, with the area from bits 15:8 and the packet from bits 7:0. Writing 0 clears both counters.
- R8: A write takes priority over packet and area events in the same cycle, and those events are discarded.
- R9: `tag_o` shows the counters before the packet advance, so the first packet in a new area reports packet number 0.
- R10: When `area_advance_i` (with `rsrc_read_i` and `wr_en_i` low) and `pkt_stored_i` are high in the same cycle, `tag_o` shows the new area with packet 0, and the packet number afterwards is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_stored_i | input | 1 | A packet was buffered in this cycle |
| area_advance_i | input | 1 | The engine moved to the next buffer area |
| rsrc_read_i | input | 1 | The current area move comes from a resource-read command |
| wr_en_i | input | 1 | Software write strobe for the counters |
| wr_data_i | input | 16 | Write value: area in 15:8, packet in 7:0 |
| tag_o | output | 16 | Sequence word for the packet stored this cycle |
| seq_word_o | output | 16 | Registered counter state |

## Verification
The bench targets five corner cases.

- **Packet-number wrap.** The packet number is driven from 255 to 0. A design that carried into the area number would report the wrong area.
- **Area-number wrap.** The area number is driven from 255 to 0.
- **Area move and packet store in one cycle.** A design that applied these in the wrong order would tag the packet with the old area, or leave the packet number at 0 instead of 1.
- **Area move caused by a resource read.** A design that did not gate these moves would bump the area number.
- **Write collides with events.** A write arrives in the same cycle as packet and area events. A design where the events won would end with a value other than the written one.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
   localparam int unsigned LANES    = 2;
   localparam int unsigned LANE_PKT = 0;
   localparam int unsigned LANE_BUF = 1;

   typedef struct packed {
      logic load;
      logic adv_area;
      logic adv_pkt;
   } rxseq_evt_t;
endpackage

// File: rtl/rxseq_evt_dec.sv
module rxseq_evt_dec
   import rxseq_pkg::*;
(
   input  logic       pkt_stored_i,
   input  logic       area_advance_i,
   input  logic       rsrc_read_i,
   input  logic       wr_en_i,
   output rxseq_evt_t evt_o
);
   // Priority: write > area move > packet store.
   // An area move caused by a resource read is discarded.
   always_comb begin
      evt_o.load     = wr_en_i;
      evt_o.adv_area = area_advance_i & ~rsrc_read_i & ~wr_en_i;
      evt_o.adv_pkt  = pkt_stored_i & ~wr_en_i;
   end
endmodule

// File: rtl/rxseq_ctr.sv
module rxseq_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] pre_o
);
   logic [W-1:0] q_r;
   logic [W-1:0] nxt;

   always_comb begin
      // Clear is applied first, so clear and increment together give 1.
      pre_o = clr_i ? '0 : q_r;
      nxt   = pre_o + W'(inc_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= '0;
      else if (load_i) q_r <= load_val_i;
      else             q_r <= nxt;
   end

   assign q_o = q_r;
endmodule

// File: rtl/rx_seq_tagger.sv
module rx_seq_tagger
   import rxseq_pkg::*;
#(
   parameter int unsigned SEQ_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pkt_stored_i,
   input  logic               area_advance_i,
   input  logic               rsrc_read_i,
   input  logic               wr_en_i,
   input  logic [2*SEQ_W-1:0] wr_data_i,
   output logic [2*SEQ_W-1:0] tag_o,
   output logic [2*SEQ_W-1:0] seq_word_o
);
   localparam int unsigned WORD_W = LANES * SEQ_W;

   if (SEQ_W < 1 || SEQ_W > 16) begin : g_bad_width
      $error("rx_seq_tagger: SEQ_W out of range");
   end

   rxseq_evt_t evt;

   rxseq_evt_dec u_dec (
      .pkt_stored_i   (pkt_stored_i),
      .area_advance_i (area_advance_i),
      .rsrc_read_i    (rsrc_read_i),
      .wr_en_i        (wr_en_i),
      .evt_o          (evt)
   );

   logic [LANES-1:0] lane_clr;
   logic [LANES-1:0] lane_inc;
   logic [WORD_W-1:0] q_word;
   logic [WORD_W-1:0] pre_word;

   always_comb begin
      lane_clr           = '0;
      lane_inc           = '0;
      lane_clr[LANE_PKT] = evt.adv_area;
      lane_inc[LANE_PKT] = evt.adv_pkt;
      lane_inc[LANE_BUF] = evt.adv_area;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SEQ_W-1:0] q;
      logic [SEQ_W-1:0] pre;

      rxseq_ctr #(.W(SEQ_W)) u_ctr (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (evt.load),
         .load_val_i (wr_data_i[g*SEQ_W +: SEQ_W]),
         .clr_i      (lane_clr[g]),
         .inc_i      (lane_inc[g]),
         .q_o        (q),
         .pre_o      (pre)
      );

      assign q_word[g*SEQ_W +: SEQ_W] = q;

      if (g == LANE_BUF) begin : g_buf_tag
         // The stored packet is tagged with the area that follows the move.
         assign pre_word[g*SEQ_W +: SEQ_W] = evt.adv_area ? q + SEQ_W'(1) : q;
      end else begin : g_pkt_tag
         assign pre_word[g*SEQ_W +: SEQ_W] = pre;
      end
   end

   assign seq_word_o = q_word;
   assign tag_o      = pre_word;
endmodule

// File: rtl/rx_seq_tagger_chk.sv
module rx_seq_tagger_chk #(
   parameter int unsigned SEQ_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pkt_stored_i,
   input logic               area_advance_i,
   input logic               rsrc_read_i,
   input logic               wr_en_i,
   input logic [2*SEQ_W-1:0] wr_data_i,
   input logic [2*SEQ_W-1:0] tag_o,
   input logic [2*SEQ_W-1:0] seq_word_o
);
   localparam int unsigned HI = 2*SEQ_W - 1;

   logic [SEQ_W-1:0] buf_n;
   logic [SEQ_W-1:0] pkt_n;
   assign buf_n = seq_word_o[HI:SEQ_W];
   assign pkt_n = seq_word_o[SEQ_W-1:0];

   assert_pkt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_stored_i && !area_advance_i && !wr_en_i) |=>
      (pkt_n == SEQ_W'($past(pkt_n) + 1'b1)) && $stable(buf_n));

   assert_area_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (area_advance_i && !rsrc_read_i && !wr_en_i && !pkt_stored_i) |=>
      (buf_n == SEQ_W'($past(buf_n) + 1'b1)) && (pkt_n == '0));

   assert_rsrc_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsrc_read_i && !pkt_stored_i && !wr_en_i) |=> $stable(seq_word_o));

   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (seq_word_o == $past(wr_data_i)));

   assert_both_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (area_advance_i && pkt_stored_i && !rsrc_read_i && !wr_en_i) |=>
      (pkt_n == SEQ_W'(1)));

   assert_tag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!area_advance_i || rsrc_read_i || wr_en_i) |-> (tag_o == seq_word_o));
endmodule

bind rx_seq_tagger rx_seq_tagger_chk #(.SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/rx_seq_tagger_bench.sv
module rx_seq_tagger_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_stored_i = 1'b0;
   logic        area_advance_i = 1'b0;
   logic        rsrc_read_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] tag_o;
   logic [15:0] seq_word_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   rx_seq_tagger u_rx_seq_tagger (.*);

   // Vector layout: req[55:52] wr[51] wdata[50:35] adv[34] rd[33] pkt[32] tag[31:16] word[15:0]
   localparam int NV = 16;
   localparam logic [55:0] VEC [NV] = '{
      {4'd9,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0001}, // R9 first packet reports 0
      {4'd3,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0002}, // R3
      {4'd4,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0100}, // R4
      {4'd9,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0100, 16'h0101}, // R9 new area, packet 0
      {4'd10, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0200, 16'h0201}, // R10
      {4'd5,  1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0201, 16'h0201}, // R5 move from resource read
      {4'd5,  1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0201, 16'h0201}, // R5 resource read alone
      {4'd7,  1'b1, 16'h12FF, 1'b0, 1'b0, 1'b0, 16'h0201, 16'h12FF}, // R7 load
      {4'd6,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h12FF, 16'h1200}, // R6 packet wrap
      {4'd7,  1'b1, 16'hFF05, 1'b0, 1'b0, 1'b0, 16'h1200, 16'hFF05}, // R7 load
      {4'd6,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6 area wrap
      {4'd8,  1'b1, 16'h3456, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h3456}, // R8 write wins
      {4'd7,  1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h3456, 16'h0000}, // R7 zero clears
      {4'd7,  1'b1, 16'hA55A, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hA55A}, // R7 load
      {4'd2,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hA55A, 16'hA55B}, // R2 field layout
      {4'd2,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hA600, 16'hA600}  // R2 area in high byte
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 word", seq_word_o, 16'h0000);
      check("R1 tag", tag_o, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr_en_i        = VEC[i][51];
         wr_data_i      = VEC[i][50:35];
         area_advance_i = VEC[i][34];
         rsrc_read_i    = VEC[i][33];
         pkt_stored_i   = VEC[i][32];
         #1;
         check($sformatf("R%0d tag vec%0d", VEC[i][55:52], i), tag_o, VEC[i][31:16]);
         @(posedge clk);
         #1;
         check($sformatf("R%0d word vec%0d", VEC[i][55:52], i), seq_word_o, VEC[i][15:0]);
      end

      // Directed: R1 reset clears a non-zero state.
      @(negedge clk);
      wr_en_i = 1'b0; area_advance_i = 1'b0; rsrc_read_i = 1'b0; pkt_stored_i = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 mid-run word", seq_word_o, 16'h0000);
      check("R1 mid-run tag", tag_o, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed: R3 255 packets then R6 wrap keeps the area at 0.
      pkt_stored_i = 1'b1;
      repeat (256) @(negedge clk);
      pkt_stored_i = 1'b0;
      #1;
      check("R6 256 packets wrap", seq_word_o, 16'h0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule